// File: doc/BRIEF.md
# Sub-Rate Time-Slot Interchange Switch

This block is a non-blocking space-time switch for four serial TDM frame ports. Each port carries a 256-bit frame of 32 eight-bit slots, sent most significant bit first, one bit for every cycle in which the shared bit strobe is high. A frame-start pulse, sampled with the strobe, marks bit 7 of slot 0. Each frame, every incoming slot is captured into one half of a double-buffered switching memory. Each outgoing slot is assembled from the other half, steered by a 14-bit connection word for that output port and slot.

A connection moves a whole byte (64 kbps), a nibble (32 kbps) or a bit pair (16 kbps) between aligned positions. A pair of adjacent output slots can also be joined into one 128 kbps connection. Every output line has a drive indication that is high only in slots that carry a connection. Idle bits are sent as 1. Connection words are loaded through a plain register write port and only take effect at a frame boundary.

The serial lines are fixed-rate TDM streams. They have no valid/ready handshake and no back-pressure: the bit strobe alone paces capture and transmit, and a bit that is presented is always consumed. The write port is a single-cycle strobe that is always accepted.

Top module: `tsi_subrate_switch`

## Requirements
- R1: A frame starts on the strobed bit where `fsync` is high. Bit k of the frame (k = 0..255) belongs to slot k/8 and carries data bit 7 - k%8. Outputs change only on a clock edge where `bit_en` is high, and each output bit appears on the edge that consumes the matching input bit position.
- R2: A slot received in frame N is available to outputs throughout frame N+1 and no sooner, so every connection has a constant delay of one frame.
- R3: With bandwidth code 00, an output slot carries the full byte of the selected source port and source slot. Any port and slot may be the source of any number of outputs.
- R4: With bandwidth code 01, a nibble moves. The low bit of the source position selects it (0 = bits 7:4, 1 = bits 3:0), and the low bit of the destination position places it the same way. The other nibble is sent as 1s.
- R5: With bandwidth code 10, a bit pair moves. Position p (0..3) covers bits 7-2p and 6-2p, for both source and destination. The other six bits are sent as 1s.
- R6: With bandwidth code 11 in output slot s, that slot carries the full source byte of source slot n. Slot s+1 carries source slot n+1 (mod 32) of the same port from the same frame. The connection word of slot s+1 is then ignored.
- R7: `tx_en` for a port is high exactly during the bits of slots that have an enabled connection word or are the tail of a 128 kbps pair. Whenever `tx_en` is low, `tx_data` is 1.
- R8: A connection word written during a frame first takes effect in the following frame. The current frame continues with the old map.
- R9: After reset, all connection words are disabled, `tx_en` is all 0 and `tx_data` is all 1.
- R10: The connection word holds, from bit 13 down: enable [13], bandwidth [12:11], source port [10:9], source slot [8:4], source position [3:2], destination position [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe; one serial bit per high cycle |
| fsync | input | 1 | Frame start, sampled with `bit_en` |
| rx_data | input | 4 | Serial input per port |
| tx_data | output | 4 | Serial output per port |
| tx_en | output | 4 | Per-port drive indication |
| cfg_we | input | 1 | Connection word write strobe |
| cfg_port | input | 2 | Output port of the word written |
| cfg_slot | input | 5 | Output slot of the word written |
| cfg_cmd | input | 14 | Connection word |

## Verification
The bench sweeps every bit of every slot on all four outputs over seven frames, under two arithmetic connection maps that cover every bandwidth code, position pair, source port and a spread of source slots. The maps include pair heads whose tail words are disabled or different. A swapped field order or a nibble placed at the wrong end shows up as wrong data bits. A design without the second memory half would give zero delay, or tear a 128 kbps pair across frames. A word applied at once instead of at the frame boundary turns frame 1 live early. A tail that obeys its own word shows up as wrong data or a low drive indication.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int CMD_W = 14;

  typedef enum logic [1:0] {
    BW_BYTE = 2'b00,
    BW_NIB  = 2'b01,
    BW_DIB  = 2'b10,
    BW_PAIR = 2'b11
  } bw_e;

  // R10: connection word layout, enable at the top
  typedef struct packed {
    logic       en;
    bw_e        bw;
    logic [1:0] sport;
    logic [4:0] sslot;
    logic [1:0] spos;
    logic [1:0] dpos;
  } conn_t;
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int NSLOTS = 32,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             fsync,
  output logic [CNT_W-1:0] pos,
  output logic             frame_start,
  output logic             wr_bank
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NSLOTS * 8 - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bank_q;

  always_comb begin
    if (fsync || cnt_q == LAST) pos = '0;
    else                        pos = cnt_q + 1'b1;
    frame_start = bit_en && (pos == '0);
    wr_bank     = frame_start ? ~bank_q : bank_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      bank_q <= 1'b0;
    end else if (bit_en) begin
      cnt_q  <= pos;
      bank_q <= wr_bank;
    end
  end

  // R1
  frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> (cnt_q == '0));

  // R2
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bank_q != $past(bank_q)));
endmodule

// File: rtl/tsi_switch_mem.sv
module tsi_switch_mem #(
  parameter int NPORTS = 4,
  parameter int NSLOTS = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [CNT_W-1:0]  pos,
  input  logic              wr_bank,
  input  logic [NPORTS-1:0] rx_data,
  output logic [7:0]        rd_bytes [NPORTS][NSLOTS]
);
  logic [7:0] mem_q [2][NPORTS][NSLOTS];
  logic [6:0] shf_q [NPORTS];

  wire                 slot_end = (pos[2:0] == 3'd7);
  wire [CNT_W-4:0]     wslot    = pos[CNT_W-1:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) begin
        shf_q[p] <= '0;
        for (int s = 0; s < NSLOTS; s++) begin
          mem_q[0][p][s] <= '0;
          mem_q[1][p][s] <= '0;
        end
      end
    end else if (bit_en) begin
      for (int p = 0; p < NPORTS; p++) begin
        shf_q[p] <= {shf_q[p][5:0], rx_data[p]};
        if (slot_end) mem_q[wr_bank][p][wslot] <= {shf_q[p], rx_data[p]};
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORTS; p++)
      for (int s = 0; s < NSLOTS; s++)
        rd_bytes[p][s] = mem_q[~wr_bank][p][s];
  end
endmodule

// File: rtl/tsi_cmd_store.sv
module tsi_cmd_store
  import tsi_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int NSLOTS = 32,
  parameter int PORT_W = 2,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [SLOT_W-1:0] slot,
  input  logic              cfg_we,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic [CMD_W-1:0]  cfg_cmd,
  output conn_t             cmd_cur  [NPORTS],
  output conn_t             cmd_prev [NPORTS]
);
  logic [NPORTS-1:0][NSLOTS-1:0][CMD_W-1:0] shadow_q, active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (frame_start) active_q <= shadow_q;
      if (cfg_we)      shadow_q[cfg_port][cfg_slot] <= cfg_cmd;
    end
  end

  always_comb begin
    for (int q = 0; q < NPORTS; q++) begin
      cmd_cur[q]  = frame_start ? conn_t'(shadow_q[q][0])
                                : conn_t'(active_q[q][slot]);
      cmd_prev[q] = (slot == '0) ? '0
                                 : conn_t'(active_q[q][slot - SLOT_W'(1)]);
    end
  end

  // R8
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_q));
endmodule

// File: rtl/tsi_slot_builder.sv
module tsi_slot_builder
  import tsi_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int NSLOTS = 32
) (
  input  conn_t      cmd_cur,
  input  conn_t      cmd_prev,
  input  logic [7:0] rd_bytes [NPORTS][NSLOTS],
  output logic [7:0] slot_byte,
  output logic       slot_live
);
  logic [7:0] src;
  logic [3:0] nib;
  logic [1:0] dib;
  logic [2:0] s_sh, d_sh;

  always_comb begin
    slot_byte = 8'hFF;
    slot_live = 1'b0;
    src  = '0;
    nib  = '0;
    dib  = '0;
    s_sh = {~cmd_cur.spos, 1'b0};
    d_sh = {~cmd_cur.dpos, 1'b0};
    if (cmd_prev.en && cmd_prev.bw == BW_PAIR) begin
      src       = rd_bytes[cmd_prev.sport][5'(cmd_prev.sslot + 5'd1)];
      slot_byte = src;
      slot_live = 1'b1;
    end else if (cmd_cur.en) begin
      src       = rd_bytes[cmd_cur.sport][cmd_cur.sslot];
      slot_live = 1'b1;
      case (cmd_cur.bw)
        BW_NIB: begin
          nib = cmd_cur.spos[0] ? src[3:0] : src[7:4];
          slot_byte = cmd_cur.dpos[0] ? {4'hF, nib} : {nib, 4'hF};
        end
        BW_DIB: begin
          dib = 2'(src >> s_sh);
          slot_byte = ~(8'b11 << d_sh) | (8'(dib) << d_sh);
        end
        default: slot_byte = src;
      endcase
    end
  end
endmodule

// File: rtl/tsi_subrate_switch.sv
module tsi_subrate_switch
  import tsi_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int NSLOTS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_en,
  input  logic                        fsync,
  input  logic [NPORTS-1:0]           rx_data,
  output logic [NPORTS-1:0]           tx_data,
  output logic [NPORTS-1:0]           tx_en,
  input  logic                        cfg_we,
  input  logic [$clog2(NPORTS)-1:0]   cfg_port,
  input  logic [$clog2(NSLOTS)-1:0]   cfg_slot,
  input  logic [CMD_W-1:0]            cfg_cmd
);
  localparam int PORT_W = $clog2(NPORTS);
  localparam int SLOT_W = $clog2(NSLOTS);
  localparam int CNT_W  = SLOT_W + 3;

  logic [CNT_W-1:0] pos;
  logic             frame_start, wr_bank;
  logic [7:0]       rd_bytes [NPORTS][NSLOTS];
  conn_t            cmd_cur  [NPORTS];
  conn_t            cmd_prev [NPORTS];
  logic [7:0]       slot_byte [NPORTS];
  logic [NPORTS-1:0] slot_live;

  wire [SLOT_W-1:0] slot    = pos[CNT_W-1:3];
  wire [2:0]        bit_sel = ~pos[2:0];

  tsi_frame_timer #(.NSLOTS(NSLOTS), .CNT_W(CNT_W)) u_timer (
    .clk, .rst_n, .bit_en, .fsync,
    .pos, .frame_start, .wr_bank
  );

  tsi_switch_mem #(.NPORTS(NPORTS), .NSLOTS(NSLOTS), .CNT_W(CNT_W)) u_mem (
    .clk, .rst_n, .bit_en, .pos, .wr_bank, .rx_data, .rd_bytes
  );

  tsi_cmd_store #(.NPORTS(NPORTS), .NSLOTS(NSLOTS),
                  .PORT_W(PORT_W), .SLOT_W(SLOT_W)) u_cmd (
    .clk, .rst_n, .frame_start, .slot,
    .cfg_we, .cfg_port, .cfg_slot, .cfg_cmd,
    .cmd_cur, .cmd_prev
  );

  for (genvar q = 0; q < NPORTS; q++) begin : g_out
    tsi_slot_builder #(.NPORTS(NPORTS), .NSLOTS(NSLOTS)) u_build (
      .cmd_cur  (cmd_cur[q]),
      .cmd_prev (cmd_prev[q]),
      .rd_bytes (rd_bytes),
      .slot_byte(slot_byte[q]),
      .slot_live(slot_live[q])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tx_data[q] <= 1'b1;
        tx_en[q]   <= 1'b0;
      end else if (bit_en) begin
        tx_data[q] <= slot_byte[q][bit_sel];
        tx_en[q]   <= slot_live[q];
      end
    end
  end

  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_data) && $stable(tx_en)));

  // R7
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_data | tx_en) == {NPORTS{1'b1}}));
endmodule

// File: tb/tb_tsi_subrate_switch.sv
module tb_tsi_subrate_switch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, fsync = 1'b0;
  logic [3:0]  rx_data = '0;
  logic [3:0]  tx_data, tx_en;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_port = '0;
  logic [4:0]  cfg_slot = '0;
  logic [13:0] cfg_cmd = '0;

  int checks = 0, fails = 0;
  logic [13:0] shadow_m [4][32];
  logic [13:0] active_m [4][32];

  always #5 clk = ~clk;

  tsi_subrate_switch dut (
    .clk, .rst_n, .bit_en, .fsync, .rx_data, .tx_data, .tx_en,
    .cfg_we, .cfg_port, .cfg_slot, .cfg_cmd
  );

  function automatic logic [7:0] rxb(int p, int s, int f);
    return 8'((p * 53 + s * 29 + f * 101 + s * s) ^ (p << 5));
  endfunction

  // R10 word packing: en, bw, sport, sslot, spos, dpos
  function automatic logic [13:0] mk_word(int k, int q, int s);
    int en, bw, sp, ss, spo, dpo;
    en  = ((s + q + k) % 6) != 5;
    bw  = (s + 2 * q + k) % 4;
    if (bw == 3 && ((s % 2) == 1 || s >= 30)) bw = 0;
    sp  = (s * 3 + q + k) % 4;
    ss  = (s * 7 + q * 5 + k * 3 + 1) % 31;
    spo = (s + q + k) % 4;
    dpo = (s * 3 + q * 2 + k) % 4;
    return {1'(en), 2'(bw), 2'(sp), 5'(ss), 2'(spo), 2'(dpo)};
  endfunction

  task automatic model(int q, int s, int f, output logic [7:0] e,
                       output logic live, output string tag);
    logic [13:0] c, pv;
    logic [7:0]  src;
    logic [3:0]  nb;
    int          fd, ds;
    c  = active_m[q][s];
    pv = (s > 0) ? active_m[q][s-1] : 14'd0;
    e = 8'hFF; live = 1'b0; tag = "R7 idle";
    if (pv[13] && pv[12:11] == 2'b11) begin
      e = rxb(pv[10:9], (pv[8:4] + 1) % 32, f - 1); live = 1'b1;
      tag = "R6 pair tail";
    end else if (c[13]) begin
      src = rxb(c[10:9], c[8:4], f - 1); live = 1'b1;
      case (c[12:11])
        2'b01: begin
          nb = c[2] ? src[3:0] : src[7:4];
          e  = c[0] ? {4'hF, nb} : {nb, 4'hF};
          tag = "R4 nibble";
        end
        2'b10: begin
          fd = (src >> (6 - 2 * c[3:2])) & 3;
          ds = 6 - 2 * c[1:0];
          e  = 8'((8'hFF & ~(3 << ds)) | (fd << ds));
          tag = "R5 bit pair";
        end
        2'b11: begin e = src; tag = "R6 pair head"; end
        default: begin e = src; tag = "R3 byte (R2 delay)"; end
      endcase
    end
  endtask

  task automatic write_map(int k);
    for (int q = 0; q < 4; q++)
      for (int s = 0; s < 32; s++) begin
        @(negedge clk);
        cfg_we = 1'b1; cfg_port = 2'(q); cfg_slot = 5'(s);
        cfg_cmd = ((k == 1) && (s % 9 == 4)) ? 14'd0 : mk_word(k, q, s);
        shadow_m[q][s] = cfg_cmd;
        @(negedge clk);
        cfg_we = 1'b0;
      end
  endtask

  initial begin
    for (int q = 0; q < 4; q++)
      for (int s = 0; s < 32; s++) begin
        shadow_m[q][s] = '0; active_m[q][s] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    checks++;
    if (tx_en !== 4'h0 || tx_data !== 4'hF) begin
      fails++;
      $display("FAIL R9 reset: tx_en=%h tx_data=%h expected 0 and f", tx_en, tx_data);
    end
    for (int f = 0; f < 7; f++) begin
      for (int b = 0; b < 256; b++) begin
        if (b == 0)
          for (int q = 0; q < 4; q++)
            for (int s = 0; s < 32; s++) active_m[q][s] = shadow_m[q][s];
        @(negedge clk);
        for (int p = 0; p < 4; p++) rx_data[p] = rxb(p, b / 8, f)[7 - b % 8];
        fsync = (b == 0); bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0; fsync = 1'b0;
        // R1: output bit b of slot b/8 appears on the strobed edge
        for (int q = 0; q < 4; q++) begin
          logic [7:0] e; logic live; string tag;
          model(q, b / 8, f, e, live, tag);
          if (f == 1 && b > 50) tag = {"R8 deferred, ", tag};
          if (f < 2) tag = {"R9 ", tag};
          checks++;
          if (tx_data[q] !== e[7 - b % 8] || tx_en[q] !== live) begin
            fails++;
            $display("FAIL %s f%0d q%0d bit%0d: data=%b en=%b expected data=%b en=%b",
                     tag, f, q, b, tx_data[q], tx_en[q], e[7 - b % 8], live);
          end
        end
        if (f == 1 && b == 50)  write_map(0);
        if (f == 4 && b == 200) write_map(1);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual=hung expected=complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule